// File: doc/BRIEF.md
# Halt and Active-Halt Power Sequencer

This block decides what a halt instruction does to the clocking of a small microcontroller and brings the device back to work afterwards. When the CPU strobes a halt, the sequencer picks one of three outcomes:

- **Full halt.** The oscillator, the peripheral clocks and the CPU clock are all stopped.
- **Low-power halt.** Only the oscillator and its time base keep running.
- **Watchdog reset.** Used when halting would leave a running watchdog with no clock.

In both halt modes the sequencer clears the CPU interrupt mask.

Wake-up comes from four sources:

- a reset request;
- an external interrupt;
- an internal interrupt that is allowed to end a halt;
- the oscillator time-base interrupt. This source works only in the low-power mode, where the oscillator is still alive.

Leaving a full halt turns the oscillator on at once. The CPU and the peripherals are then held off for a fixed stabilisation window counted on the oscillator clock. Leaving the low-power halt skips that window. At resume, the sequencer gives a one-cycle indication to the CPU, together with a latched cause bit. The cause bit selects either a reset-vector fetch or interrupt service. Interrupt service is preceded by a request to push the condition codes.

Top module: `halt_seq`

## Requirements
- R1: After `rstN` is released, the block is in the running state: `oscEn`, `periphEn` and `cpuEn` are 1; `iBitClr`, `wdgReset`, `wakeValid` and `pushCc` are 0; `wakeIsReset` is 1.
- R2: A `haltStrobe` while running, with `oscIntEn`=0 and with either `wdgEnable`=0 or `wdgHaltOk`=1, enters full halt from the next cycle. In full halt, `oscEn`, `periphEn` and `cpuEn` are 0 and `iBitClr` is 1.
- R3: A `haltStrobe` while running with `oscIntEn`=1 enters low-power halt from the next cycle. In low-power halt, `oscEn` is 1, `periphEn` and `cpuEn` are 0, and `iBitClr` is 1.
- R4: A `haltStrobe` while running, with `oscIntEn`=0, `wdgEnable`=1 and `wdgHaltOk`=0, raises `wdgReset` for exactly one cycle, starting the next cycle. All clock enables stay 1 and no halt is entered.
- R5: With `oscIntEn`=1, a `haltStrobe` enters low-power halt and never raises `wdgReset`, whatever the watchdog inputs are.
- R6: Full halt is left only on `resetReq`, `extIrq` or `intIrqExit`. `oscTbIrq` has no effect in full halt.
- R7: Low-power halt is left on any of `resetReq`, `extIrq`, `intIrqExit` or `oscTbIrq`. The resume cycle directly follows the cycle in which the event was sampled, with no stabilisation wait.
- R8: On exit from full halt, `oscEn` is 1 from the cycle after the event. `periphEn` and `cpuEn` stay 0 for exactly 4096 cycles (the `STAB_CYCLES` default) before the resume cycle.
- R9: The resume cycle has `wakeValid`=1 with all three enables at 1. In that cycle, `wakeIsReset` is 1 if the wake cause was `resetReq` and 0 for an interrupt. `pushCc` is 1 in that cycle only when the cause is an interrupt.
- R10: Wake events that arrive during the stabilisation window are ignored. They neither change the latched cause nor restart the count.
- R11: When `resetReq` and an interrupt are sampled in the same cycle, the cause latches as reset (`wakeIsReset`=1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-derived clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| haltStrobe | input | 1 | One-cycle strobe for the halt instruction |
| oscIntEn | input | 1 | Oscillator time-base interrupt enabled |
| wdgEnable | input | 1 | Watchdog is running |
| wdgHaltOk | input | 1 | Option bit: halt allowed while the watchdog runs |
| extIrq | input | 1 | External interrupt |
| intIrqExit | input | 1 | Internal interrupt that is able to end a halt |
| oscTbIrq | input | 1 | Oscillator time-base interrupt |
| resetReq | input | 1 | Reset request acting as a wake cause |
| oscEn | output | 1 | Oscillator enable |
| periphEn | output | 1 | Peripheral clock enable |
| cpuEn | output | 1 | CPU clock enable |
| iBitClr | output | 1 | Drives the interrupt mask bit to 0 |
| wdgReset | output | 1 | Watchdog reset pulse |
| wakeValid | output | 1 | One-cycle resume indication |
| wakeIsReset | output | 1 | Latched cause: 1 = reset vector, 0 = interrupt |
| pushCc | output | 1 | Request to push the condition codes before interrupt service |

## Verification
A state register stuck in, or steered to, the wrong mode shows up on the clock enables in the very next cycle. Examples are low-power halt taken for full halt, or a watchdog pulse on a redirected halt. A counter that loads wrongly, or that restarts on a late event, moves the resume by at least one cycle; the scoreboard catches this by comparing the exact cycle of `wakeValid`. A wrong cause latch is visible on `wakeIsReset` and `pushCc` in the resume cycle itself.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_HALT   = 3'd1,
    ST_AHALT  = 3'd2,
    ST_STAB   = 3'd3,
    ST_RESUME = 3'd4,
    ST_WDRST  = 3'd5
  } haltState_t;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic latchCause;
    logic causeReset;
  } dpCtl_t;
endpackage

// File: rtl/halt_seq_dp.sv
module halt_seq_dp
  import halt_seq_pkg::*;
#(
  parameter int STAB_CYCLES = 4096
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCtl_t ctl,
  output logic   cntZero,
  output logic   causeIsReset
);
  localparam int CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STAB_CYCLES - 1);

  logic [CNT_W-1:0] stabCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stabCnt <= '0;
    end else if (ctl.loadCnt) begin
      stabCnt <= LOAD_VAL;
    end else if (ctl.decCnt) begin
      stabCnt <= stabCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeIsReset <= 1'b1;
    end else if (ctl.latchCause) begin
      causeIsReset <= ctl.causeReset;
    end
  end

  assign cntZero = (stabCnt == '0);
endmodule

// File: rtl/halt_seq_ctrl.sv
module halt_seq_ctrl
  import halt_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   haltStrobe,
  input  logic   oscIntEn,
  input  logic   wdgEnable,
  input  logic   wdgHaltOk,
  input  logic   extIrq,
  input  logic   intIrqExit,
  input  logic   oscTbIrq,
  input  logic   resetReq,
  input  logic   cntZero,
  input  logic   causeIsReset,
  output dpCtl_t ctl,
  output logic   oscEn,
  output logic   periphEn,
  output logic   cpuEn,
  output logic   iBitClr,
  output logic   wdgReset,
  output logic   wakeValid,
  output logic   pushCc
);
  haltState_t state, stateNxt;
  logic haltWake;
  logic activeWake;

  assign haltWake   = resetReq | extIrq | intIrqExit;
  assign activeWake = haltWake | oscTbIrq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt       = state;
    ctl            = '0;
    ctl.causeReset = resetReq;
    unique case (state)
      ST_RUN: begin
        if (haltStrobe) begin
          if (oscIntEn)                     stateNxt = ST_AHALT;
          else if (wdgEnable && !wdgHaltOk) stateNxt = ST_WDRST;
          else                              stateNxt = ST_HALT;
        end
      end
      ST_HALT: begin
        if (haltWake) begin
          ctl.loadCnt    = 1'b1;
          ctl.latchCause = 1'b1;
          stateNxt       = ST_STAB;
        end
      end
      ST_AHALT: begin
        if (activeWake) begin
          ctl.latchCause = 1'b1;
          stateNxt       = ST_RESUME;
        end
      end
      ST_STAB: begin
        if (cntZero) stateNxt   = ST_RESUME;
        else         ctl.decCnt = 1'b1;
      end
      ST_RESUME: stateNxt = ST_RUN;
      ST_WDRST:  stateNxt = ST_RUN;
      default:   stateNxt = ST_RUN;
    endcase
  end

  always_comb begin
    oscEn     = (state != ST_HALT);
    cpuEn     = (state == ST_RUN) || (state == ST_RESUME) || (state == ST_WDRST);
    periphEn  = cpuEn;
    iBitClr   = (state == ST_HALT) || (state == ST_AHALT);
    wdgReset  = (state == ST_WDRST);
    wakeValid = (state == ST_RESUME);
    pushCc    = wakeValid && !causeIsReset;
  end
endmodule

// File: rtl/halt_seq.sv
module halt_seq
  import halt_seq_pkg::*;
#(
  parameter int STAB_CYCLES = 4096
) (
  input  logic clk,
  input  logic rstN,
  input  logic haltStrobe,
  input  logic oscIntEn,
  input  logic wdgEnable,
  input  logic wdgHaltOk,
  input  logic extIrq,
  input  logic intIrqExit,
  input  logic oscTbIrq,
  input  logic resetReq,
  output logic oscEn,
  output logic periphEn,
  output logic cpuEn,
  output logic iBitClr,
  output logic wdgReset,
  output logic wakeValid,
  output logic wakeIsReset,
  output logic pushCc
);
  dpCtl_t ctl;
  logic   cntZero;

  halt_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .haltStrobe(haltStrobe), .oscIntEn(oscIntEn),
    .wdgEnable(wdgEnable), .wdgHaltOk(wdgHaltOk), .extIrq(extIrq),
    .intIrqExit(intIrqExit), .oscTbIrq(oscTbIrq), .resetReq(resetReq),
    .cntZero(cntZero), .causeIsReset(wakeIsReset), .ctl(ctl),
    .oscEn(oscEn), .periphEn(periphEn), .cpuEn(cpuEn), .iBitClr(iBitClr),
    .wdgReset(wdgReset), .wakeValid(wakeValid), .pushCc(pushCc)
  );

  halt_seq_dp #(.STAB_CYCLES(STAB_CYCLES)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cntZero(cntZero), .causeIsReset(wakeIsReset)
  );
endmodule

// File: rtl/halt_seq_chk.sv
module halt_seq_chk #(
  parameter int STAB_CYCLES = 4096
) (
  input logic clk,
  input logic rstN,
  input logic haltStrobe,
  input logic oscIntEn,
  input logic extIrq,
  input logic intIrqExit,
  input logic oscTbIrq,
  input logic resetReq,
  input logic oscEn,
  input logic periphEn,
  input logic cpuEn,
  input logic iBitClr,
  input logic wdgReset,
  input logic wakeValid,
  input logic wakeIsReset,
  input logic pushCc
);
  localparam int LW = $clog2(STAB_CYCLES + 1) + 1;
  localparam logic [LW-1:0] STAB_N = LW'(STAB_CYCLES);

  logic          inStab;
  logic [LW-1:0] runLen;

  assign inStab = oscEn && !cpuEn && !iBitClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       runLen <= '0;
    else if (!inStab) runLen <= '0;
    else if (runLen != '1) runLen <= runLen + 1'b1;
  end

  AST_HALT_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> (!periphEn && !cpuEn && iBitClr)); // R2

  AST_WDG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wdgReset |-> (cpuEn && oscEn) ##1 !wdgReset); // R4

  AST_WDG_SUPPRESSED: assert property (@(posedge clk) disable iff (!rstN)
    (haltStrobe && oscIntEn && cpuEn) |=> !wdgReset); // R5

  AST_HALT_TB_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEn && oscTbIrq && !resetReq && !extIrq && !intIrqExit) |=> !oscEn); // R6

  AST_ACTIVE_WAKE_NOW: assert property (@(posedge clk) disable iff (!rstN)
    (oscEn && iBitClr && oscTbIrq) |=> wakeValid); // R7

  AST_STAB_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    inStab |-> (runLen < STAB_N)); // R8

  AST_STAB_EXACT_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inStab) && !inStab) |-> (wakeValid && runLen == STAB_N)); // R8

  AST_WAKE_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    wakeValid |-> (oscEn && periphEn && cpuEn && !iBitClr)); // R9

  AST_PUSH_ONLY_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    pushCc |-> (wakeValid && !wakeIsReset)); // R9

  AST_RESET_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (iBitClr && resetReq) |=> wakeIsReset); // R11
endmodule

bind halt_seq halt_seq_chk #(.STAB_CYCLES(STAB_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .haltStrobe(haltStrobe), .oscIntEn(oscIntEn),
  .extIrq(extIrq), .intIrqExit(intIrqExit), .oscTbIrq(oscTbIrq),
  .resetReq(resetReq), .oscEn(oscEn), .periphEn(periphEn), .cpuEn(cpuEn),
  .iBitClr(iBitClr), .wdgReset(wdgReset), .wakeValid(wakeValid),
  .wakeIsReset(wakeIsReset), .pushCc(pushCc)
);

// File: tb/halt_seq_test.sv
module halt_seq_test;
  localparam int STAB = 4096;

  logic clk = 1'b0;
  logic rstN;
  logic haltStrobe, oscIntEn, wdgEnable, wdgHaltOk;
  logic extIrq, intIrqExit, oscTbIrq, resetReq;
  logic oscEn, periphEn, cpuEn, iBitClr, wdgReset, wakeValid, wakeIsReset, pushCc;

  int unsigned cyc = 0;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct {
    bit          cause;
    int unsigned when;
  } wakeItem_t;
  wakeItem_t expQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  halt_seq #(.STAB_CYCLES(STAB)) uut (
    .clk(clk), .rstN(rstN), .haltStrobe(haltStrobe), .oscIntEn(oscIntEn),
    .wdgEnable(wdgEnable), .wdgHaltOk(wdgHaltOk), .extIrq(extIrq),
    .intIrqExit(intIrqExit), .oscTbIrq(oscTbIrq), .resetReq(resetReq),
    .oscEn(oscEn), .periphEn(periphEn), .cpuEn(cpuEn), .iBitClr(iBitClr),
    .wdgReset(wdgReset), .wakeValid(wakeValid), .wakeIsReset(wakeIsReset),
    .pushCc(pushCc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Driver side: apply a wake source for one edge and queue the expected resume.
  task automatic wakeAndExpect(input bit cause, input int unsigned delay);
    int unsigned tEdge;
    @(posedge clk);
    #1 tEdge = cyc;
    expQ.push_back('{cause: cause, when: tEdge + delay});
    @(negedge clk);
    extIrq = 1'b0; intIrqExit = 1'b0; oscTbIrq = 1'b0; resetReq = 1'b0;
  endtask

  task automatic waitWake();
    int guard = 0;
    while (!wakeValid && guard < 2 * STAB) begin
      tick();
      guard++;
    end
    tick();
  endtask

  task automatic doHalt();
    haltStrobe = 1'b1;
    tick();
    haltStrobe = 1'b0;
  endtask

  // Monitor: pop and compare each resume against the scoreboard.
  always @(negedge clk) begin
    if (rstN && wakeValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected wake", 1, 0);
      end else begin
        wakeItem_t e;
        e = expQ.pop_front();
        check(cyc == e.when, "R8 resume cycle", int'(cyc), int'(e.when));
        check(wakeIsReset == e.cause, "R9 cause bit", int'(wakeIsReset), int'(e.cause));
        check(pushCc == !e.cause, "R9 push request", int'(pushCc), int'(!e.cause));
        check(cpuEn && periphEn && oscEn, "R9 enables at resume",
              int'({oscEn, periphEn, cpuEn}), 7);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 200000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    haltStrobe = 1'b0; oscIntEn = 1'b0; wdgEnable = 1'b0; wdgHaltOk = 1'b0;
    extIrq = 1'b0; intIrqExit = 1'b0; oscTbIrq = 1'b0; resetReq = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    check(oscEn && periphEn && cpuEn, "R1 enables", int'({oscEn, periphEn, cpuEn}), 7);
    check(!iBitClr && !wdgReset && !wakeValid && !pushCc, "R1 strobes",
          int'({iBitClr, wdgReset, wakeValid, pushCc}), 0);
    check(wakeIsReset == 1'b1, "R1 cause", int'(wakeIsReset), 1);

    // R2 full halt, watchdog off
    doHalt();
    check({oscEn, periphEn, cpuEn} == 3'b000, "R2 clocks off", int'({oscEn, periphEn, cpuEn}), 0);
    check(iBitClr == 1'b1, "R2 mask clear", int'(iBitClr), 1);

    // R6 time-base interrupt ignored in full halt
    oscTbIrq = 1'b1;
    tick();
    oscTbIrq = 1'b0;
    tick();
    check(!oscEn && !cpuEn && !wakeValid, "R6 stays halted",
          int'({oscEn, cpuEn, wakeValid}), 0);

    // R8 external wake with stabilisation; R10 late events ignored
    extIrq = 1'b1;
    wakeAndExpect(1'b0, STAB);
    check(oscEn && !cpuEn && !periphEn, "R8 osc on, cpu held",
          int'({oscEn, periphEn, cpuEn}), 4);
    repeat (100) tick();
    resetReq = 1'b1; extIrq = 1'b1;
    tick();
    resetReq = 1'b0; extIrq = 1'b0;
    check(!cpuEn, "R10 still stabilising", int'(cpuEn), 0);
    waitWake();
    check(cpuEn && !wakeValid, "R9 back to run", int'({cpuEn, wakeValid}), 2);

    // R3 low-power halt and R7 time-base wake without delay
    oscIntEn = 1'b1;
    doHalt();
    check({oscEn, periphEn, cpuEn} == 3'b100, "R3 osc only", int'({oscEn, periphEn, cpuEn}), 4);
    check(iBitClr == 1'b1, "R3 mask clear", int'(iBitClr), 1);
    repeat (5) tick();
    oscTbIrq = 1'b1;
    wakeAndExpect(1'b0, 0);
    tick();

    // R5 watchdog reset suppressed; R11 reset wins over simultaneous interrupt
    wdgEnable = 1'b1; wdgHaltOk = 1'b0;
    doHalt();
    check(!wdgReset, "R5 no watchdog reset", int'(wdgReset), 0);
    check(oscEn && !cpuEn, "R5 low-power halt", int'({oscEn, cpuEn}), 2);
    tick();
    check(!wdgReset, "R5 no late watchdog reset", int'(wdgReset), 0);
    resetReq = 1'b1; extIrq = 1'b1;
    wakeAndExpect(1'b1, 0);
    tick();

    // R7 internal interrupt leaves low-power halt
    doHalt();
    intIrqExit = 1'b1;
    wakeAndExpect(1'b0, 0);
    tick();

    // R4 watchdog reset instead of full halt
    oscIntEn = 1'b0;
    doHalt();
    check(wdgReset == 1'b1, "R4 watchdog pulse", int'(wdgReset), 1);
    check(oscEn && periphEn && cpuEn, "R4 clocks stay on", int'({oscEn, periphEn, cpuEn}), 7);
    tick();
    check(!wdgReset && cpuEn, "R4 single pulse, no halt", int'({wdgReset, cpuEn}), 1);

    // R2 watchdog allowed in halt; wake by internal interrupt
    wdgHaltOk = 1'b1;
    doHalt();
    check(!oscEn && !wdgReset, "R2 halt with watchdog allowed", int'({oscEn, wdgReset}), 0);
    intIrqExit = 1'b1;
    wakeAndExpect(1'b0, STAB);
    waitWake();

    // R9 reset wake from full halt selects reset vector
    doHalt();
    resetReq = 1'b1;
    wakeAndExpect(1'b1, STAB);
    waitWake();

    check(expQ.size() == 0, "R9 all wakes seen", expQ.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule